// File: doc/BRIEF.md
# Load/Store-Multiple Sequencer with Abort Recovery

This block executes a block data transfer for a small processor core. Given a 16-bit mask of selected registers, a base register index, and flags for direction (up/down), pre/post indexing, write-back and load/store, it moves one word per selected register. The words travel over a single-outstanding valid/ready memory bus, and the block updates its own 16-entry register file. Registers always go out in ascending index order at ascending addresses. A descending transfer therefore starts at the base minus four bytes per selected register.

Memory aborts are handled differently for the two directions. A store keeps issuing every remaining word and reports the abort only when the instruction finishes. A load stops at the first aborted read and makes the instruction restartable:
- no later register is written, and the aborting target keeps its value;
- the register loaded just before the abort is rolled back;
- the base register is set back to its starting value, or to its final address when write-back was requested.

The core loads operands through an idle-time write port and reads results through a read port. A one-cycle done pulse ends every instruction, with an abort flag beside it when a data-abort must be taken.

Top module: `ldm_seq`

## Requirements
- R1: With up=1 the accesses start at the base; with up=0 they start at base minus 4×N, where N is the number of set bits in the list. When pre equals up, the first access is at that start plus 4; otherwise it is at the start itself. Each later access is 4 bytes above the previous one.
- R2: Bit i of the list selects register i. Selected registers are transferred lowest index first, one bus access each, so the lowest selected register uses the lowest address.
- R3: When the base index is 15, the base value is pc_i + 8. Register 15 never receives a write-back or a base restore.
- R4: If no access aborts, write-back is set and the base index is not 15, the base register ends at base + 4×N (up) or base − 4×N (down). This value replaces any value loaded into the base register during the transfer.
- R5: On a store, an aborted access does not stop the sequence: every selected word is still issued. abort_o is high only in the done_o cycle.
- R6: On a load, the first aborted read ends all bus accesses. The register that read targets, and all later registers in the list, keep their old values.
- R7: On a load abort, the register written by the immediately preceding read is restored to its value from before that read. If the first read aborts, nothing is restored.
- R8: On a load abort with base index not 15, the base register ends at its starting value without write-back, or at the R4 final address with write-back.
- R9: An empty list performs no bus access, raises no abort, and still gives a done pulse.
- R10: mem_valid_o is high only while busy. The address stays stable until mem_ready_i. done_o is a single-cycle pulse.
- R11: After reset all registers read zero and busy_o, done_o, abort_o and mem_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an instruction (sampled when idle) |
| list_i | input | 16 | Register selection mask |
| base_i | input | 4 | Base register index |
| pc_i | input | 32 | Program counter value |
| up_i | input | 1 | 1 = ascending, 0 = descending |
| pre_i | input | 1 | Pre-index flag |
| wb_i | input | 1 | Write-back request |
| load_i | input | 1 | 1 = load, 0 = store |
| wr_en_i | input | 1 | Register write from the core (idle only) |
| wr_idx_i | input | 4 | Register write index |
| wr_data_i | input | 32 | Register write data |
| rd_idx_i | input | 4 | Register read index |
| rd_data_o | output | 32 | Register read data |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle end-of-instruction pulse |
| abort_o | output | 1 | Data-abort request, valid with done_o |
| mem_valid_o | output | 1 | Bus request |
| mem_ready_i | input | 1 | Bus accepts/completes the access |
| mem_we_o | output | 1 | 1 = write access |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Load data |
| mem_abort_i | input | 1 | Access aborted, sampled with mem_ready_i |

## Verification
The bench builds the block with its default 16 registers and 32-bit words, so every index is reachable, including the program-counter base. A 64-word memory model serves the bus and can abort any chosen address. It can also insert zero to two wait cycles per access, which exercises address holding under back-pressure. Aborts are placed on the first, middle and last words, and the base register is placed inside the list, so that rollback, base restore and write-back interact in every order.

// File: rtl/ldm_pkg.sv
package ldm_pkg;
    parameter int unsigned LDM_NREG = 16;
    parameter int unsigned LDM_DW   = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_UNDO,
        ST_FIN
    } seq_st_e;
endpackage

// File: rtl/ldm_regfile.sv
module ldm_regfile #(
    parameter int unsigned NREG  = 16,
    parameter int unsigned DW    = 32,
    localparam int unsigned IW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ra_idx,
    output logic [DW-1:0] ra_data,
    input  logic [IW-1:0] rb_idx,
    output logic [DW-1:0] rb_data,
    input  logic [IW-1:0] rc_idx,
    output logic [DW-1:0] rc_data
);
    logic [DW-1:0] rf_q [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NREG); i++) rf_q[i] <= '0;
        end else if (we) begin
            rf_q[widx] <= wdata;
        end
    end

    assign ra_data = rf_q[ra_idx];
    assign rb_data = rf_q[rb_idx];
    assign rc_data = rf_q[rc_idx];
endmodule

// File: rtl/ldm_pick.sv
module ldm_pick #(
    parameter int unsigned NREG = 16,
    localparam int unsigned IW  = $clog2(NREG),
    localparam int unsigned CW  = $clog2(NREG + 1)
) (
    input  logic [NREG-1:0] mask,
    output logic [IW-1:0]   low_idx,
    output logic            any,
    output logic [CW-1:0]   count
);
    always_comb begin
        low_idx = '0;
        count   = '0;
        for (int i = int'(NREG) - 1; i >= 0; i--) begin
            if (mask[i]) low_idx = IW'(i);
        end
        for (int i = 0; i < int'(NREG); i++) begin
            count = count + CW'(mask[i]);
        end
    end

    assign any = |mask;
endmodule

// File: rtl/ldm_addr.sv
module ldm_addr #(
    parameter int unsigned DW   = 32,
    parameter int unsigned NREG = 16,
    localparam int unsigned CW  = $clog2(NREG + 1),
    localparam int unsigned STEP = DW / 8
) (
    input  logic [DW-1:0] base_val,
    input  logic [CW-1:0] count,
    input  logic          up,
    input  logic          pre,
    output logic [DW-1:0] first_addr,
    output logic [DW-1:0] final_addr
);
    logic [DW-1:0] span;
    logic [DW-1:0] low;

    always_comb begin
        span       = DW'(count) * DW'(STEP);
        low        = up ? base_val : base_val - span;
        first_addr = (pre == up) ? low + DW'(STEP) : low;
        final_addr = up ? base_val + span : base_val - span;
    end
endmodule

// File: rtl/ldm_seq.sv
module ldm_seq
    import ldm_pkg::*;
#(
    parameter int unsigned NREG = LDM_NREG,
    parameter int unsigned DW   = LDM_DW,
    localparam int unsigned IW  = $clog2(NREG),
    localparam int unsigned CW  = $clog2(NREG + 1),
    localparam int unsigned STEP = DW / 8,
    localparam logic [IW-1:0] PC_IDX = IW'(NREG - 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [NREG-1:0] list_i,
    input  logic [IW-1:0]   base_i,
    input  logic [DW-1:0]   pc_i,
    input  logic            up_i,
    input  logic            pre_i,
    input  logic            wb_i,
    input  logic            load_i,
    input  logic            wr_en_i,
    input  logic [IW-1:0]   wr_idx_i,
    input  logic [DW-1:0]   wr_data_i,
    input  logic [IW-1:0]   rd_idx_i,
    output logic [DW-1:0]   rd_data_o,
    output logic            busy_o,
    output logic            done_o,
    output logic            abort_o,
    output logic            mem_valid_o,
    input  logic            mem_ready_i,
    output logic            mem_we_o,
    output logic [DW-1:0]   mem_addr_o,
    output logic [DW-1:0]   mem_wdata_o,
    input  logic [DW-1:0]   mem_rdata_i,
    input  logic            mem_abort_i
);
    typedef struct packed {
        seq_st_e         st;
        logic [NREG-1:0] rem;
        logic [DW-1:0]   acc;
        logic [DW-1:0]   init;
        logic [DW-1:0]   fin;
        logic [IW-1:0]   base;
        logic            load;
        logic            wb;
        logic            abort;
        logic            prev_v;
        logic [IW-1:0]   prev_idx;
        logic [DW-1:0]   prev_old;
    } seq_t;

    seq_t seq_d, seq_q;

    // register file write port (single, arbitrated below)
    logic          rf_we;
    logic [IW-1:0] rf_widx;
    logic [DW-1:0] rf_wdata;
    logic [DW-1:0] cur_data;
    logic [DW-1:0] base_rd;

    // selection helpers
    logic [IW-1:0] start_low_unused;
    logic          start_any;
    logic [CW-1:0] start_cnt;
    logic [IW-1:0] cur_idx;
    logic          cur_any_unused;
    logic [CW-1:0] cur_cnt_unused;
    logic [DW-1:0] base_val;
    logic [DW-1:0] first_addr;
    logic [DW-1:0] final_addr;
    logic [NREG-1:0] rem_next;

    ldm_regfile #(.NREG(NREG), .DW(DW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .widx    (rf_widx),
        .wdata   (rf_wdata),
        .ra_idx  (rd_idx_i),
        .ra_data (rd_data_o),
        .rb_idx  (cur_idx),
        .rb_data (cur_data),
        .rc_idx  (base_i),
        .rc_data (base_rd)
    );

    ldm_pick #(.NREG(NREG)) u_pick_start (
        .mask    (list_i),
        .low_idx (start_low_unused),
        .any     (start_any),
        .count   (start_cnt)
    );

    ldm_pick #(.NREG(NREG)) u_pick_cur (
        .mask    (seq_q.rem),
        .low_idx (cur_idx),
        .any     (cur_any_unused),
        .count   (cur_cnt_unused)
    );

    assign base_val = (base_i == PC_IDX) ? pc_i + DW'(2 * STEP) : base_rd;

    ldm_addr #(.DW(DW), .NREG(NREG)) u_addr (
        .base_val   (base_val),
        .count      (start_cnt),
        .up         (up_i),
        .pre        (pre_i),
        .first_addr (first_addr),
        .final_addr (final_addr)
    );

    assign rem_next = seq_q.rem & ~(NREG'(1) << cur_idx);

    always_comb begin
        seq_d    = seq_q;
        rf_we    = 1'b0;
        rf_widx  = '0;
        rf_wdata = '0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (wr_en_i) begin
                    rf_we    = 1'b1;
                    rf_widx  = wr_idx_i;
                    rf_wdata = wr_data_i;
                end
                if (start_i) begin
                    seq_d.rem    = list_i;
                    seq_d.acc    = first_addr;
                    seq_d.init   = base_val;
                    seq_d.fin    = final_addr;
                    seq_d.base   = base_i;
                    seq_d.load   = load_i;
                    seq_d.wb     = wb_i;
                    seq_d.abort  = 1'b0;
                    seq_d.prev_v = 1'b0;
                    seq_d.st     = start_any ? ST_XFER : ST_FIN;
                end
            end
            ST_XFER: begin
                if (mem_ready_i) begin
                    seq_d.rem = rem_next;
                    seq_d.acc = seq_q.acc + DW'(STEP);
                    if (seq_q.load) begin
                        if (mem_abort_i) begin
                            seq_d.abort = 1'b1;
                            seq_d.st    = ST_UNDO;
                        end else begin
                            rf_we          = 1'b1;
                            rf_widx        = cur_idx;
                            rf_wdata       = mem_rdata_i;
                            seq_d.prev_v   = 1'b1;
                            seq_d.prev_idx = cur_idx;
                            seq_d.prev_old = cur_data;
                            if (rem_next == '0) seq_d.st = ST_FIN;
                        end
                    end else begin
                        seq_d.abort = seq_q.abort | mem_abort_i;
                        if (rem_next == '0) seq_d.st = ST_FIN;
                    end
                end
            end
            ST_UNDO: begin
                if (seq_q.prev_v) begin
                    rf_we    = 1'b1;
                    rf_widx  = seq_q.prev_idx;
                    rf_wdata = seq_q.prev_old;
                end
                seq_d.st = ST_FIN;
            end
            ST_FIN: begin
                if (seq_q.base != PC_IDX) begin
                    if (seq_q.wb) begin
                        rf_we    = 1'b1;
                        rf_widx  = seq_q.base;
                        rf_wdata = seq_q.fin;
                    end else if (seq_q.abort && seq_q.load) begin
                        rf_we    = 1'b1;
                        rf_widx  = seq_q.base;
                        rf_wdata = seq_q.init;
                    end
                end
                seq_d.st = ST_IDLE;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o      = seq_q.st != ST_IDLE;
    assign done_o      = seq_q.st == ST_FIN;
    assign abort_o     = done_o && seq_q.abort;
    assign mem_valid_o = seq_q.st == ST_XFER;
    assign mem_we_o    = !seq_q.load;
    assign mem_addr_o  = seq_q.acc;
    assign mem_wdata_o = cur_data;

    // R10
    bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_valid_o);
    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o)));
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R5
    abort_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> done_o);
    // R6
    load_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && mem_ready_i && mem_abort_i && !mem_we_o) |=> !mem_valid_o);
    // R1
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && mem_ready_i) |=>
            (!mem_valid_o || mem_addr_o == $past(mem_addr_o) + DW'(STEP)));
endmodule

// File: tb/ldm_seq_tb.sv
module ldm_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] list_i = '0;
    logic [3:0]  base_i = '0;
    logic [31:0] pc_i = '0;
    logic        up_i = 1'b0, pre_i = 1'b0, wb_i = 1'b0, load_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  wr_idx_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [3:0]  rd_idx_i = '0;
    logic [31:0] rd_data_o;
    logic        busy_o, done_o, abort_o;
    logic        mem_valid_o, mem_we_o;
    logic        mem_ready_i = 1'b0;
    logic [31:0] mem_addr_o, mem_wdata_o;
    logic [31:0] mem_rdata_i = '0;
    logic        mem_abort_i = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int stall_cfg = 0;
    int wait_cnt = 0;
    int nacc = 0;
    int early_abort = 0;
    logic        abort_en = 1'b0;
    logic [31:0] abort_addr = '0;
    logic [31:0] log_addr [16];
    logic [31:0] log_data [16];
    logic [31:0] mem [64];
    logic        got_abort;

    ldm_seq u_dut (.*);

    always #4 clk = ~clk;

    function automatic logic [31:0] mval(input logic [31:0] a);
        return 32'hC0DE_0000 | {26'd0, a[7:2]};
    endfunction

    // memory model: responses driven away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (abort_o && !done_o) early_abort++;
        if (mem_valid_o) begin
            if (wait_cnt >= stall_cfg) begin
                mem_ready_i = 1'b1;
                wait_cnt    = 0;
            end else begin
                mem_ready_i = 1'b0;
                wait_cnt++;
            end
            mem_rdata_i = mem[mem_addr_o[7:2]];
            mem_abort_i = abort_en && (mem_addr_o == abort_addr);
        end else begin
            mem_ready_i = 1'b0;
            mem_abort_i = 1'b0;
        end
    end

    always @(posedge clk) begin
        if (mem_valid_o && mem_ready_i) begin
            if (nacc < 16) begin
                log_addr[nacc] = mem_addr_o;
                log_data[nacc] = mem_wdata_o;
            end
            nacc++;
            if (mem_we_o && !mem_abort_i) mem[mem_addr_o[7:2]] = mem_wdata_o;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input int i, output logic [31:0] v);
        rd_idx_i = 4'(i);
        #1;
        v = rd_data_o;
    endtask

    task automatic wr(input int i, input logic [31:0] v);
        @(negedge clk);
        wr_en_i   = 1'b1;
        wr_idx_i  = 4'(i);
        wr_data_i = v;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic init_mem();
        for (int i = 0; i < 64; i++) mem[i] = mval(32'(i * 4));
    endtask

    task automatic run(input logic [15:0] lst, input int b, input logic up, input logic pre,
                       input logic wb, input logic ld);
        logic seen;
        nacc = 0;
        early_abort = 0;
        seen = 1'b0;
        @(negedge clk);
        list_i = lst; base_i = 4'(b); up_i = up; pre_i = pre; wb_i = wb; load_i = ld;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 400; k++) begin
            if (done_o) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
        got_abort = abort_o;
        chk("R10 done pulse seen", 32'(seen), 32'd1);
        @(negedge clk);
        chk("R10 done is one cycle", 32'(done_o), 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R11 busy after reset", 32'(busy_o), 32'd0);
        chk("R11 done after reset", 32'(done_o), 32'd0);
        chk("R11 abort after reset", 32'(abort_o), 32'd0);
        chk("R11 valid after reset", 32'(mem_valid_o), 32'd0);
        for (int i = 0; i < 16; i++) begin
            rd(i, v);
            chk("R11 register zero", v, 32'd0);
        end
    endtask

    task automatic t_store_up_post();
        logic [31:0] v;
        stall_cfg = 0;
        wr(1, 32'd11); wr(3, 32'd33); wr(7, 32'd77); wr(2, 32'h40);
        run(16'h008A, 2, 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R2 access count", 32'(nacc), 32'd3);
        chk("R1 up/post addr0", log_addr[0], 32'h40);
        chk("R1 up/post addr2", log_addr[2], 32'h48);
        chk("R2 lowest reg first", log_data[0], 32'd11);
        chk("R2 middle reg", log_data[1], 32'd33);
        chk("R2 highest reg last", log_data[2], 32'd77);
        chk("R5 no abort", 32'(got_abort), 32'd0);
        rd(2, v);
        chk("R4 write-back up", v, 32'h4C);
    endtask

    task automatic t_load_down_pre();
        logic [31:0] v;
        stall_cfg = 1;
        wr(5, 32'h80);
        run(16'h0015, 5, 1'b0, 1'b1, 1'b1, 1'b1);
        chk("R1 down/pre addr0", log_addr[0], 32'h74);
        chk("R1 down/pre addr2", log_addr[2], 32'h7C);
        rd(0, v); chk("R2 load r0", v, mval(32'h74));
        rd(2, v); chk("R2 load r2", v, mval(32'h78));
        rd(4, v); chk("R2 load r4", v, mval(32'h7C));
        rd(5, v); chk("R4 write-back down", v, 32'h74);
    endtask

    task automatic t_load_up_pre();
        logic [31:0] v;
        stall_cfg = 0;
        wr(6, 32'h20);
        run(16'h0300, 6, 1'b1, 1'b1, 1'b0, 1'b1);
        chk("R1 up/pre addr0", log_addr[0], 32'h24);
        chk("R1 up/pre addr1", log_addr[1], 32'h28);
        rd(9, v); chk("R2 load r9", v, mval(32'h28));
        rd(6, v); chk("R4 base kept without write-back", v, 32'h20);
    endtask

    task automatic t_store_down_post();
        stall_cfg = 2;
        wr(8, 32'h808); wr(9, 32'h909);
        run(16'h0300, 6, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R1 down/post count", 32'(nacc), 32'd2);
        chk("R1 down/post addr0", log_addr[0], 32'h1C);
        chk("R1 down/post addr1", log_addr[1], 32'h20);
        chk("R2 down store r8", log_data[0], 32'h808);
        chk("R2 down store r9", log_data[1], 32'h909);
    endtask

    task automatic t_pc_base();
        logic [31:0] v;
        stall_cfg = 0;
        wr(15, 32'h123);
        pc_i = 32'h30;
        run(16'h0002, 15, 1'b1, 1'b0, 1'b1, 1'b1);
        pc_i = 32'h0;
        chk("R3 pc base addr", log_addr[0], 32'h38);
        rd(1, v); chk("R3 pc base load", v, mval(32'h38));
        rd(15, v); chk("R3 no write-back to r15", v, 32'h123);
    endtask

    task automatic t_empty();
        logic [31:0] v;
        wr(4, 32'h44);
        run(16'h0000, 4, 1'b1, 1'b0, 1'b1, 1'b1);
        chk("R9 no accesses", 32'(nacc), 32'd0);
        chk("R9 no abort", 32'(got_abort), 32'd0);
        rd(4, v); chk("R9 base unchanged", v, 32'h44);
    endtask

    task automatic t_store_abort();
        logic [31:0] v;
        stall_cfg = 1;
        wr(1, 32'h111); wr(2, 32'h222); wr(3, 32'h333); wr(4, 32'h40);
        abort_en = 1'b1; abort_addr = 32'h44;
        run(16'h000E, 4, 1'b1, 1'b0, 1'b1, 1'b0);
        abort_en = 1'b0;
        chk("R5 all stores issued", 32'(nacc), 32'd3);
        chk("R5 last store addr", log_addr[2], 32'h48);
        chk("R5 abort at done", 32'(got_abort), 32'd1);
        chk("R5 abort not early", 32'(early_abort), 32'd0);
        rd(4, v); chk("R4 store write-back after abort", v, 32'h4C);
    endtask

    task automatic t_load_abort_mid();
        logic [31:0] v;
        stall_cfg = 0;
        init_mem();
        wr(0, 32'h60);
        wr(1, 32'h101); wr(2, 32'h102); wr(3, 32'h103); wr(4, 32'h104);
        abort_en = 1'b1; abort_addr = 32'h68;
        run(16'h001E, 0, 1'b1, 1'b0, 1'b0, 1'b1);
        abort_en = 1'b0;
        chk("R6 accesses stop at abort", 32'(nacc), 32'd3);
        chk("R6 abort flagged", 32'(got_abort), 32'd1);
        rd(1, v); chk("R7 earlier load kept", v, mval(32'h60));
        rd(2, v); chk("R7 prior load rolled back", v, 32'h102);
        rd(3, v); chk("R6 aborting target kept", v, 32'h103);
        rd(4, v); chk("R6 later reg kept", v, 32'h104);
        rd(0, v); chk("R8 base restored", v, 32'h60);
    endtask

    task automatic t_load_abort_wb_base_in_list();
        logic [31:0] v;
        wr(2, 32'h202); wr(3, 32'h50); wr(5, 32'h505);
        abort_en = 1'b1; abort_addr = 32'h58;
        run(16'h002C, 3, 1'b1, 1'b0, 1'b1, 1'b1);
        abort_en = 1'b0;
        rd(2, v); chk("R7 first load kept", v, mval(32'h50));
        rd(3, v); chk("R8 base gets final address", v, 32'h5C);
        rd(5, v); chk("R6 aborting target kept", v, 32'h505);
    endtask

    task automatic t_load_abort_base_restore();
        logic [31:0] v;
        stall_cfg = 2;
        wr(3, 32'h50); wr(4, 32'h404); wr(5, 32'h505);
        abort_en = 1'b1; abort_addr = 32'h58;
        run(16'h0038, 3, 1'b1, 1'b0, 1'b0, 1'b1);
        abort_en = 1'b0;
        rd(3, v); chk("R8 loaded base restored", v, 32'h50);
        rd(4, v); chk("R7 rollback of r4", v, 32'h404);
        rd(5, v); chk("R6 r5 kept", v, 32'h505);
    endtask

    task automatic t_load_abort_first();
        logic [31:0] v;
        stall_cfg = 0;
        wr(1, 32'h111); wr(2, 32'h222); wr(7, 32'h10);
        abort_en = 1'b1; abort_addr = 32'h10;
        run(16'h0006, 7, 1'b1, 1'b0, 1'b0, 1'b1);
        abort_en = 1'b0;
        chk("R6 single access", 32'(nacc), 32'd1);
        chk("R6 abort flagged", 32'(got_abort), 32'd1);
        rd(1, v); chk("R7 nothing to restore r1", v, 32'h111);
        rd(2, v); chk("R6 r2 untouched", v, 32'h222);
        rd(7, v); chk("R8 base kept", v, 32'h10);
    endtask

    task automatic t_wb_overrides_load();
        logic [31:0] v;
        wr(2, 32'h40);
        run(16'h0006, 2, 1'b1, 1'b0, 1'b1, 1'b1);
        rd(1, v); chk("R4 r1 loaded", v, mval(32'h40));
        rd(2, v); chk("R4 write-back beats loaded base", v, 32'h48);
    endtask

    initial begin
        init_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_store_up_post();
        t_load_down_pre();
        t_load_up_pre();
        t_store_down_post();
        t_pc_base();
        t_empty();
        t_store_abort();
        t_load_abort_mid();
        t_load_abort_wb_base_in_list();
        t_load_abort_base_restore();
        t_load_abort_first();
        t_wb_overrides_load();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule